// File: doc/BRIEF.md
# Serial Channel Buffer Pair with Hardware Handshake

This block holds the outgoing and incoming characters of one asynchronous serial channel. The receive buffer keeps each character together with its three error flags, so the status of a byte comes out with that byte. It shows its occupancy at all times and raises a service request once the occupancy reaches a host-chosen trigger. It also drives the active-low request-to-send pin high when the occupancy climbs to a flow-control threshold. The transmit buffer hands characters to an external shifter one at a time. It withholds the next character while the synchronized clear-to-send pin is high.

A serial receiver pushes into the receive side and the host pops from it. The host pushes into the transmit side and the shifter takes characters by raising `tx_ready`. Each handshake can be switched from automatic to manual with its own enable bit. A single clear input empties both buffers at once.

Top module: `chan_fifo_flow`

## Requirements
- R1: While `rst_n` is low at a clock edge, both levels become 0, `rx_req`, `rx_ovr` and `tx_start` become 0, `rts_n` becomes 1, and `rx_dout`, `rx_err_out` and `tx_char` become 0.
- R2: Receive characters leave in push order. In the clock after a pop of a non-empty buffer, `rx_dout` and `rx_err_out` show the oldest stored byte and its flags (bit 0 parity, bit 1 framing, bit 2 break).
- R3: `rx_level` and `tx_level` give the stored count after each edge and never exceed DEPTH (32). A push raises the count by one and a pop lowers it by one. A push and a pop together leave it unchanged. A push into a full buffer is dropped.
- R4: A receive push while the buffer holds 32 entries sets `rx_ovr` on the next edge. The flag stays set until a clock edge with `lsr_rd` high and no new overrun.
- R5: A pop of an empty buffer leaves `rx_dout`, `rx_err_out` and the level unchanged.
- R6: `rx_req` is 1 exactly when `rx_level` is non-zero and `rx_level >= rx_trig`.
- R7: With `auto_rts_en` high, `rts_n` becomes 1 one clock after `rx_level >= rts_thr`. It returns to 0 one clock after the level falls below `rts_thr`.
- R8: With `auto_rts_en` low, `rts_n` becomes the inverse of `sw_rts` one clock later, whatever the level.
- R9: `tx_start` pulses for one clock after a cycle in which `tx_ready` is high, the transmit buffer is non-empty, sending is permitted and `tx_start` is low. `tx_char` carries that character in push order. No two pulses are adjacent.
- R10: `cts_n` passes through a two-stage synchronizer. With `auto_cts_en` high and the synchronized `cts_n` high, no `tx_start` occurs. With `auto_cts_en` low, `cts_n` has no effect.
- R11: `fifo_clr` sets both levels to 0 on the next edge and discards all stored characters. It takes priority over any push or pop in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fifo_clr | input | 1 | Empty both buffers |
| rx_push | input | 1 | Store a received character |
| rx_din | input | 8 | Received character |
| rx_err_in | input | 3 | Flags of the received character |
| rx_pop | input | 1 | Host takes a character |
| rx_dout | output | 8 | Last character taken |
| rx_err_out | output | 3 | Flags of the last character taken |
| rx_level | output | 6 | Receive occupancy |
| rx_trig | input | 6 | Service-request trigger level |
| rx_req | output | 1 | Receive service request |
| lsr_rd | input | 1 | Host read of line status, clears overrun |
| rx_ovr | output | 1 | Sticky receive overrun |
| tx_push | input | 1 | Host stores a character to send |
| tx_din | input | 8 | Character to send |
| tx_level | output | 6 | Transmit occupancy |
| tx_ready | input | 1 | Shifter is idle and wants a character |
| tx_start | output | 1 | One-clock launch pulse to the shifter |
| tx_char | output | 8 | Character being launched |
| auto_rts_en | input | 1 | Automatic request-to-send enable |
| sw_rts | input | 1 | Manual request-to-send value (1 = assert) |
| rts_thr | input | 6 | Flow-control threshold |
| rts_n | output | 1 | Active-low request-to-send pin |
| auto_cts_en | input | 1 | Automatic clear-to-send enable |
| cts_n | input | 1 | Active-low clear-to-send pin, asynchronous |

## Verification
The assertions assume that `rx_trig` and `rts_thr` stay at or below 32. They also assume the shifter lowers `tx_ready` or leaves it as it is, without depending on a second pulse. The stimulus keeps all configuration inputs stable while a sweep runs. It lowers `tx_ready` before it changes `cts_n` in the middle of a transfer, so the two-clock synchronizer window never lets a character through that the bench does not expect. The bench changes every input just after a falling edge, so all the assertions see inputs that are settled.

// File: rtl/chan_fifo_pkg.sv
// Shared constants and types for the serial channel buffer pair.
// Assumes: flag bit positions are fixed (0 parity, 1 framing, 2 break).
package chan_fifo_pkg;
    localparam int FLAG_W = 3;

    typedef struct packed {
        logic brk;
        logic frame;
        logic parity;
    } rx_flags_t;
endpackage

// File: rtl/byte_ring.sv
// Circular buffer with an occupancy count and a registered output word.
// Assumes: DEPTH is a power of two; pushes into a full buffer and pops of
// an empty buffer are ignored; clr outranks push and pop.
module byte_ring #(
    parameter int DEPTH = 32,
    parameter int W     = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          pop,
    output logic [W-1:0]  dout,
    output logic [LW-1:0] level
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic          is_full, is_empty, do_push, do_pop;

    assign is_full  = (level == LW'(DEPTH));
    assign is_empty = (level == '0);
    assign do_push  = push && !is_full && !clr;
    assign do_pop   = pop && !is_empty && !clr;

    // Storage write; no reset needed since occupancy guards every read.
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= din;
    end

    // Pointers, occupancy and the output word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
            dout   <= '0;
        end else if (clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (do_push) wr_ptr <= wr_ptr + AW'(1);
            if (do_pop) begin
                rd_ptr <= rd_ptr + AW'(1);
                dout   <= mem[rd_ptr];
            end
            case ({do_push, do_pop})
                2'b10:   level <= level + LW'(1);
                2'b01:   level <= level - LW'(1);
                default: level <= level;
            endcase
        end
    end

    assert_level_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        level <= LW'(DEPTH));
    assert_empty_pop_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && is_empty && !push && !clr) |=> ($stable(dout) && level == '0));
    assert_clear_empties_R11: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (level == '0));
endmodule

// File: rtl/pin_sync.sv
// Multi-stage synchronizer for an asynchronous input pin.
// Assumes: STAGES >= 2; RST_VAL is the pin's inactive level.
module pin_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] stg;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        // One flop of the chain; the first samples the pin.
        always_ff @(posedge clk) begin
            if (!rst_n)      stg[g] <= RST_VAL;
            else if (g == 0) stg[g] <= d;
            else             stg[g] <= stg[(g == 0) ? 0 : g - 1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/rts_ctrl.sv
// Drives the active-low request-to-send pin from the receive occupancy
// or from a manual bit. Assumes: thr is at most DEPTH.
module rts_ctrl #(
    parameter int LW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          auto_en,
    input  logic          sw_rts,
    input  logic [LW-1:0] level,
    input  logic [LW-1:0] thr,
    output logic          rts_n
);
    // Registered pin value: high (stop) at or above threshold in auto mode.
    always_ff @(posedge clk) begin
        if (!rst_n)       rts_n <= 1'b1;
        else if (auto_en) rts_n <= (level >= thr);
        else              rts_n <= !sw_rts;
    end

    assert_rts_stops_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_en && level >= thr) |=> rts_n);
    assert_rts_manual_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!auto_en && sw_rts) |=> !rts_n);
endmodule

// File: rtl/chan_fifo_flow.sv
// Receive and transmit buffers for one serial channel, with an automatic
// request-to-send and clear-to-send handshake.
// Assumes: rx_trig and rts_thr <= DEPTH; the shifter treats each tx_start
// pulse as one character.
module chan_fifo_flow #(
    parameter int DEPTH       = 32,
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2,
    localparam int FW         = chan_fifo_pkg::FLAG_W,
    localparam int LW         = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fifo_clr,
    input  logic              rx_push,
    input  logic [DATA_W-1:0] rx_din,
    input  logic [FW-1:0]     rx_err_in,
    input  logic              rx_pop,
    output logic [DATA_W-1:0] rx_dout,
    output logic [FW-1:0]     rx_err_out,
    output logic [LW-1:0]     rx_level,
    input  logic [LW-1:0]     rx_trig,
    output logic              rx_req,
    input  logic              lsr_rd,
    output logic              rx_ovr,
    input  logic              tx_push,
    input  logic [DATA_W-1:0] tx_din,
    output logic [LW-1:0]     tx_level,
    input  logic              tx_ready,
    output logic              tx_start,
    output logic [DATA_W-1:0] tx_char,
    input  logic              auto_rts_en,
    input  logic              sw_rts,
    input  logic [LW-1:0]     rts_thr,
    output logic              rts_n,
    input  logic              auto_cts_en,
    input  logic              cts_n
);
    import chan_fifo_pkg::*;

    rx_flags_t                rx_flags_in;
    logic [DATA_W+FW-1:0]     rx_word_in, rx_word_out;
    logic                     rx_full, tx_empty, cts_n_s, cts_ok, grant;

    assign rx_flags_in = rx_flags_t'(rx_err_in);
    assign rx_word_in  = {rx_flags_in, rx_din};
    assign rx_dout     = rx_word_out[DATA_W-1:0];
    assign rx_err_out  = rx_word_out[DATA_W+FW-1:DATA_W];
    assign rx_full     = (rx_level == LW'(DEPTH));
    assign rx_req      = (rx_level != '0) && (rx_level >= rx_trig);

    byte_ring #(.DEPTH(DEPTH), .W(DATA_W + FW)) u_rx_ring (
        .clk(clk), .rst_n(rst_n), .clr(fifo_clr),
        .push(rx_push), .din(rx_word_in), .pop(rx_pop),
        .dout(rx_word_out), .level(rx_level)
    );

    // Sticky overrun: a dropped push sets it, a status read clears it.
    always_ff @(posedge clk) begin
        if (!rst_n)                              rx_ovr <= 1'b0;
        else if (rx_push && rx_full && !fifo_clr) rx_ovr <= 1'b1;
        else if (lsr_rd)                         rx_ovr <= 1'b0;
    end

    rts_ctrl #(.LW(LW)) u_rts (
        .clk(clk), .rst_n(rst_n), .auto_en(auto_rts_en), .sw_rts(sw_rts),
        .level(rx_level), .thr(rts_thr), .rts_n(rts_n)
    );

    pin_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_cts_sync (
        .clk(clk), .rst_n(rst_n), .d(cts_n), .q(cts_n_s)
    );

    assign tx_empty = (tx_level == '0);
    assign cts_ok   = !auto_cts_en || !cts_n_s;
    assign grant    = tx_ready && !tx_empty && cts_ok && !tx_start && !fifo_clr;

    byte_ring #(.DEPTH(DEPTH), .W(DATA_W)) u_tx_ring (
        .clk(clk), .rst_n(rst_n), .clr(fifo_clr),
        .push(tx_push), .din(tx_din), .pop(grant),
        .dout(tx_char), .level(tx_level)
    );

    // Launch pulse, aligned with the character loaded into tx_char.
    always_ff @(posedge clk) begin
        if (!rst_n) tx_start <= 1'b0;
        else        tx_start <= grant;
    end

    assert_overrun_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_push && rx_full && !fifo_clr) |=> rx_ovr);
    assert_start_permitted_R10: assert property (@(posedge clk) disable iff (!rst_n)
        tx_start |-> $past(!auto_cts_en || !cts_n_s));
    assert_start_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        tx_start |=> !tx_start);
endmodule

// File: tb/chan_fifo_flow_bench.sv
module chan_fifo_flow_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic fifo_clr = 0, rx_push = 0, rx_pop = 0, lsr_rd = 0, tx_push = 0, tx_ready = 0;
    logic [7:0] rx_din = 0, tx_din = 0;
    logic [2:0] rx_err_in = 0;
    logic [5:0] rx_trig = 6'd5, rts_thr = 6'd28;
    logic auto_rts_en = 1, sw_rts = 0, auto_cts_en = 1, cts_n = 1;
    logic [7:0] rx_dout, tx_char;
    logic [2:0] rx_err_out;
    logic [5:0] rx_level, tx_level;
    logic rx_req, rx_ovr, tx_start, rts_n;

    int nvec = 0, nerr = 0;

    chan_fifo_flow u_chan_fifo_flow (
        .clk(clk), .rst_n(rst_n), .fifo_clr(fifo_clr),
        .rx_push(rx_push), .rx_din(rx_din), .rx_err_in(rx_err_in),
        .rx_pop(rx_pop), .rx_dout(rx_dout), .rx_err_out(rx_err_out),
        .rx_level(rx_level), .rx_trig(rx_trig), .rx_req(rx_req),
        .lsr_rd(lsr_rd), .rx_ovr(rx_ovr), .tx_push(tx_push), .tx_din(tx_din),
        .tx_level(tx_level), .tx_ready(tx_ready), .tx_start(tx_start),
        .tx_char(tx_char), .auto_rts_en(auto_rts_en), .sw_rts(sw_rts),
        .rts_thr(rts_thr), .rts_n(rts_n), .auto_cts_en(auto_cts_en), .cts_n(cts_n)
    );

    always #10 clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        nvec++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    function automatic logic [7:0] rxd(input int i);
        return 8'((i * 37 + 11) & 255);
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end

    initial begin
        int n;
        logic prev;
        repeat (3) step();
        chk("R1 rx_level", rx_level, 0);
        chk("R1 tx_level", tx_level, 0);
        chk("R1 rts_n", rts_n, 1);
        chk("R1 rx_ovr", rx_ovr, 0);
        chk("R1 tx_start", tx_start, 0);
        chk("R1 rx_req", rx_req, 0);
        chk("R1 rx_dout", rx_dout, 0);
        rst_n = 1;
        step();

        // Fill receive side: level, trigger and auto RTS after every push
        for (int i = 0; i < 32; i++) begin
            rx_push = 1; rx_din = rxd(i); rx_err_in = 3'(i % 8);
            step();
            rx_push = 0;
            chk("R3 rx_level fill", rx_level, i + 1);
            chk("R6 rx_req fill", rx_req, (i + 1 >= 5) ? 1 : 0);
            chk("R7 rts_n fill", rts_n, (i >= 28) ? 1 : 0);
        end
        step();
        chk("R7 rts_n full", rts_n, 1);

        // Overrun
        rx_push = 1; rx_din = 8'hEE; step(); rx_push = 0;
        chk("R3 rx_level drop", rx_level, 32);
        chk("R4 rx_ovr set", rx_ovr, 1);
        step();
        chk("R4 rx_ovr sticky", rx_ovr, 1);
        lsr_rd = 1; step(); lsr_rd = 0;
        chk("R4 rx_ovr cleared", rx_ovr, 0);

        // Drain in order with flags
        for (int i = 0; i < 32; i++) begin
            rx_pop = 1; step(); rx_pop = 0;
            chk("R2 rx_dout", rx_dout, rxd(i));
            chk("R2 rx_err_out", rx_err_out, i % 8);
            chk("R3 rx_level drain", rx_level, 31 - i);
            chk("R7 rts_n drain", rts_n, (32 - i >= 28) ? 1 : 0);
        end

        // Pop of empty buffer
        rx_pop = 1; step(); rx_pop = 0;
        chk("R5 rx_dout hold", rx_dout, rxd(31));
        chk("R5 rx_err_out hold", rx_err_out, 7);
        chk("R5 rx_level", rx_level, 0);
        rx_trig = 0; step();
        chk("R6 rx_req empty trig0", rx_req, 0);

        // Trigger sweep at level 10
        for (int k = 0; k < 10; k++) begin
            rx_push = 1; rx_din = 8'(8'h40 + k); rx_err_in = 3'd0; step();
        end
        rx_push = 0;
        for (int t = 0; t <= 32; t++) begin
            rx_trig = 6'(t); step();
            chk("R6 rx_req sweep", rx_req, (10 >= t) ? 1 : 0);
        end

        // Push and pop together
        rx_push = 1; rx_pop = 1; rx_din = 8'h99; step(); rx_push = 0; rx_pop = 0;
        chk("R3 rx_level push+pop", rx_level, 10);
        chk("R2 rx_dout push+pop", rx_dout, 8'h40);

        // Threshold boundary and manual mode
        rts_thr = 6'd10; step(); step();
        chk("R7 rts_n at thr", rts_n, 1);
        rts_thr = 6'd11; step(); step();
        chk("R7 rts_n below thr", rts_n, 0);
        auto_rts_en = 0; sw_rts = 0; step(); step();
        chk("R8 rts_n manual off", rts_n, 1);
        sw_rts = 1; step();
        chk("R8 rts_n manual on", rts_n, 0);
        auto_rts_en = 1; rts_thr = 6'd28;

        // Clear with concurrent push
        for (int k = 0; k < 3; k++) begin
            tx_push = 1; tx_din = 8'(k); step();
        end
        tx_push = 0;
        fifo_clr = 1; rx_push = 1; tx_push = 1; step();
        fifo_clr = 0; rx_push = 0; tx_push = 0;
        chk("R11 rx_level clr", rx_level, 0);
        chk("R11 tx_level clr", tx_level, 0);
        rx_pop = 1; step(); rx_pop = 0;
        chk("R11 rx_level after clr pop", rx_level, 0);

        // Transmit blocked by CTS
        for (int k = 0; k < 6; k++) begin
            tx_push = 1; tx_din = 8'(8'hA0 + 3 * k); step();
        end
        tx_push = 0;
        chk("R3 tx_level", tx_level, 6);
        tx_ready = 1;
        n = 0;
        for (int c = 0; c < 12; c++) begin
            step();
            if (tx_start) n++;
        end
        chk("R10 no start while cts_n high", n, 0);
        chk("R10 tx_level held", tx_level, 6);
        cts_n = 0;
        n = 0; prev = 0;
        for (int c = 0; c < 40; c++) begin
            step();
            if (tx_start) begin
                chk("R9 tx_char order", tx_char, 8'hA0 + 3 * n);
                chk("R9 no adjacent pulse", prev, 0);
                n++;
            end
            prev = tx_start;
        end
        chk("R9 start count", n, 6);
        chk("R9 tx_level drained", tx_level, 0);
        tx_ready = 0;

        // CTS ignored when auto disabled
        cts_n = 1; auto_cts_en = 0;
        for (int k = 0; k < 2; k++) begin
            tx_push = 1; tx_din = 8'(8'h10 + k); step();
        end
        tx_push = 0; tx_ready = 1; n = 0;
        for (int c = 0; c < 12; c++) begin
            step();
            if (tx_start) begin
                chk("R10 tx_char manual", tx_char, 8'h10 + n);
                n++;
            end
        end
        chk("R10 starts with auto off", n, 2);
        tx_ready = 0;

        // Transmit full
        for (int k = 0; k < 33; k++) begin
            tx_push = 1; tx_din = 8'(k); step();
        end
        tx_push = 0;
        chk("R3 tx_level full", tx_level, 32);

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end
endmodule